// File: doc/BRIEF.md
# Store Miss Merging Buffer

This block sits between the first-level data cache and the next memory level. It collects store misses on their way out. Every store names a 32-byte line, carries a full line of data and a byte-enable mask. A store whose line already has an open entry is folded into that entry: its enables are ORed into the entry's byte-valid mask and its enabled bytes replace the stored ones. A store to any other line takes a free entry. When every entry is in use and the incoming line matches none of them, the input is held off by dropping `st_ready`.

At most one open entry is offered to the outbound bus at any time. When the bus grants it, the entry closes and is released. The kind of request is read from the entry's mask at the moment of the grant. A line whose 32 bytes are all written needs only an address-only ownership claim, because the whole line will be overwritten and no data has to be fetched. A partly written line needs a read-with-intent-to-modify, which has a data tenure.

Top module: `store_merge_buf`

## Requirements
- R1: After reset, `bus_req_valid` is 0 and `st_ready` is 1.
- R2: An accepted store whose line has no open entry takes the lowest-index free entry. The entry's mask equals the store's enables, and bytes the store did not enable read as zero. Byte b of a line is `data[8b+7:8b]` and is enabled by `be[b]`.
- R3: An accepted store whose line has an open entry (one not being granted in that cycle) ORs its enables into that entry's mask. It overwrites only the enabled bytes, and every other byte keeps its earlier value.
- R4: `bus_req_kind` is 1 (address-only claim) when all 32 bits of `bus_req_mask` are set. Otherwise it is 0 (read-with-intent-to-modify). It follows the entry's current mask, so it is the mask seen at the grant that counts.
- R5: When every entry is open and none matches the incoming line, `st_ready` is 0 and the store leaves no trace. A store that matches an open line is still accepted while the buffer is full.
- R6: A cycle with `bus_grant` high and `bus_req_valid` high closes the presented entry at that clock edge. A store to the same line in that cycle or later opens a new entry that holds only its own bytes.
- R7: `bus_req_valid` is high exactly when some entry is open, and the presented entry is the open entry with the lowest index. `bus_grant` while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Store miss offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_line | input | LINE_AW (27) | Line address of the store |
| st_data | input | 256 | Store data, byte b in bits 8b+7:8b |
| st_be | input | 32 | Byte enables, bit b enables byte b |
| bus_grant | input | 1 | Bus accepts the presented request |
| bus_req_valid | output | 1 | A request is presented |
| bus_req_kind | output | 1 | 0 read-with-intent-to-modify, 1 address-only claim |
| bus_req_line | output | LINE_AW (27) | Line address of the presented entry |
| bus_req_mask | output | 32 | Byte-valid mask of the presented entry |
| bus_req_data | output | 256 | Merged line data of the presented entry |

## Verification
The bench covers these corner cases:
- Stores that overwrite bytes already held. A design that ORed the data instead of replacing it would present mixed bytes.
- Two halves that together complete a line. A design that decided the request kind from the last store alone would issue a read-for-ownership for a line it fully owns.
- A full buffer. A design that accepted a ninth line would later present a line that never belonged there. A design that stalled a matching store would lose a merge.
- A store and a grant to the same line in the same cycle. A design that merged into the departing entry would drop that store's bytes from the new entry.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int LINE_BYTES = 32;
    localparam int LINE_BITS  = LINE_BYTES * 8;

    typedef enum logic {
        REQ_RWITM = 1'b0,
        REQ_CLAIM = 1'b1
    } req_kind_e;

    typedef logic [LINE_BITS-1:0]  line_data_t;
    typedef logic [LINE_BYTES-1:0] line_mask_t;

    // Replace the enabled bytes of old_line with those of new_line.
    function automatic line_data_t merge_bytes(line_data_t old_line,
                                               line_data_t new_line,
                                               line_mask_t be);
        line_data_t res;
        for (int b = 0; b < LINE_BYTES; b++) begin
            res[b*8 +: 8] = be[b] ? new_line[b*8 +: 8] : old_line[b*8 +: 8];
        end
        return res;
    endfunction

    function automatic req_kind_e kind_of(line_mask_t mask);
        return (&mask) ? REQ_CLAIM : REQ_RWITM;
    endfunction

endpackage

// File: rtl/smb_pick.sv
module smb_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot,
    output logic         any
);
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            onehot[i] = req[i] && !seen;
            seen      = seen || req[i];
        end
        any = seen;
    end
endmodule

// File: rtl/smb_entry.sv
module smb_entry
    import smb_pkg::*;
#(
    parameter int LINE_AW = 27
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic               merge,
    input  logic               drop,
    input  logic [LINE_AW-1:0] line_in,
    input  line_data_t         data_in,
    input  line_mask_t         be_in,
    output logic               valid_o,
    output logic [LINE_AW-1:0] line_o,
    output line_data_t         data_o,
    output line_mask_t         mask_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            line_o  <= '0;
            data_o  <= '0;
            mask_o  <= '0;
        end else if (drop) begin
            valid_o <= 1'b0;
            mask_o  <= '0;
        end else if (alloc) begin
            valid_o <= 1'b1;
            line_o  <= line_in;
            mask_o  <= be_in;
            data_o  <= merge_bytes('0, data_in, be_in);
        end else if (merge) begin
            mask_o  <= mask_o | be_in;
            data_o  <= merge_bytes(data_o, data_in, be_in);
        end
    end
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
    import smb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int LINE_AW = 27
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [LINE_AW-1:0]    st_line,
    input  logic [LINE_BITS-1:0]  st_data,
    input  logic [LINE_BYTES-1:0] st_be,
    input  logic                  bus_grant,
    output logic                  bus_req_valid,
    output logic                  bus_req_kind,
    output logic [LINE_AW-1:0]    bus_req_line,
    output logic [LINE_BYTES-1:0] bus_req_mask,
    output logic [LINE_BITS-1:0]  bus_req_data
);
    logic [NUM_ENT-1:0] ent_valid;
    logic [LINE_AW-1:0] ent_line [NUM_ENT];
    line_data_t         ent_data [NUM_ENT];
    line_mask_t         ent_mask [NUM_ENT];

    logic [NUM_ENT-1:0] sel_oh, free_oh, hit_vec, alloc_vec, merge_vec, drop_vec;
    logic               sel_any, free_any, hit_any, fire, alloc_any;

    smb_pick #(.N(NUM_ENT)) u_sel  (.req(ent_valid),  .onehot(sel_oh),  .any(sel_any));
    smb_pick #(.N(NUM_ENT)) u_free (.req(~ent_valid), .onehot(free_oh), .any(free_any));

    // An entry being granted this cycle is closed to merging.
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            hit_vec[i] = ent_valid[i] && (ent_line[i] == st_line)
                         && !(bus_grant && sel_oh[i]);
        end
    end

    assign hit_any   = |hit_vec;
    assign st_ready  = hit_any || free_any;
    assign fire      = st_valid && st_ready;
    assign merge_vec = fire ? hit_vec : '0;
    assign alloc_vec = (fire && !hit_any) ? free_oh : '0;
    assign drop_vec  = bus_grant ? sel_oh : '0;
    assign alloc_any = |alloc_vec;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        smb_entry #(.LINE_AW(LINE_AW)) u_ent (
            .clk     (clk),
            .rst     (rst),
            .alloc   (alloc_vec[g]),
            .merge   (merge_vec[g]),
            .drop    (drop_vec[g]),
            .line_in (st_line),
            .data_in (st_data),
            .be_in   (st_be),
            .valid_o (ent_valid[g]),
            .line_o  (ent_line[g]),
            .data_o  (ent_data[g]),
            .mask_o  (ent_mask[g])
        );
    end

    always_comb begin
        logic [LINE_AW-1:0] l;
        line_data_t         d;
        line_mask_t         m;
        l = '0;
        d = '0;
        m = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (sel_oh[i]) begin
                l = l | ent_line[i];
                d = d | ent_data[i];
                m = m | ent_mask[i];
            end
        end
        bus_req_line = l;
        bus_req_data = d;
        bus_req_mask = m;
    end

    assign bus_req_valid = sel_any;
    assign bus_req_kind  = kind_of(bus_req_mask);

endmodule

// File: rtl/smb_chk.sv
module smb_chk #(
    parameter int NUM_ENT = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               st_ready,
    input logic               bus_grant,
    input logic               bus_req_valid,
    input logic               bus_req_kind,
    input logic [31:0]        bus_req_mask,
    input logic [NUM_ENT-1:0] ent_valid,
    input logic               alloc_any
);
    // R4
    kind_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && (&bus_req_mask)) |-> bus_req_kind);

    // R4
    kind_rwitm_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !(&bus_req_mask)) |-> !bus_req_kind);

    // R7
    req_any_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid == (|ent_valid));

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !st_ready |-> (&ent_valid));

    // R6
    grant_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && bus_req_valid) |=>
            ($countones(ent_valid) + 1 ==
             $past($countones(ent_valid)) + ($past(alloc_any) ? 1 : 0)));
endmodule

bind store_merge_buf smb_chk #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st_ready      (st_ready),
    .bus_grant     (bus_grant),
    .bus_req_valid (bus_req_valid),
    .bus_req_kind  (bus_req_kind),
    .bus_req_mask  (bus_req_mask),
    .ent_valid     (ent_valid),
    .alloc_any     (alloc_any)
);

// File: tb/sim_store_merge_buf.sv
module sim_store_merge_buf;
    localparam int NE = 8;
    localparam int AW = 27;
    localparam int LB = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            st_valid = 1'b0;
    logic            st_ready;
    logic [AW-1:0]   st_line = '0;
    logic [LB*8-1:0] st_data = '0;
    logic [LB-1:0]   st_be = '0;
    logic            bus_grant = 1'b0;
    logic            bus_req_valid, bus_req_kind;
    logic [AW-1:0]   bus_req_line;
    logic [LB-1:0]   bus_req_mask;
    logic [LB*8-1:0] bus_req_data;

    always #5 clk = ~clk;

    store_merge_buf u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_line(st_line), .st_data(st_data), .st_be(st_be),
        .bus_grant(bus_grant), .bus_req_valid(bus_req_valid),
        .bus_req_kind(bus_req_kind), .bus_req_line(bus_req_line),
        .bus_req_mask(bus_req_mask), .bus_req_data(bus_req_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference: byte-array model
    logic          m_valid [NE];
    logic [AW-1:0] m_line  [NE];
    logic [LB-1:0] m_mask  [NE];
    logic [7:0]    m_data  [NE][LB];

    // {op(1=grant), line id[3:0], be[31:0], fill[7:0]}
    localparam logic [44:0] VEC [12] = '{
        {1'b0, 4'd1, 32'h0000_000F, 8'h10},
        {1'b0, 4'd1, 32'h0000_00F0, 8'h20},
        {1'b0, 4'd1, 32'h0000_00FF, 8'h30},
        {1'b0, 4'd2, 32'hFFFF_0000, 8'h40},
        {1'b0, 4'd2, 32'h0000_FFFF, 8'h50},
        {1'b1, 4'd0, 32'h0,         8'h00},
        {1'b1, 4'd0, 32'h0,         8'h00},
        {1'b0, 4'd3, 32'hFFFF_FFFF, 8'h60},
        {1'b0, 4'd4, 32'h8000_0001, 8'h70},
        {1'b1, 4'd0, 32'h0,         8'h00},
        {1'b0, 4'd4, 32'h0000_0100, 8'h80},
        {1'b1, 4'd0, 32'h0,         8'h00}
    };

    function automatic logic [LB*8-1:0] mk_data(logic [7:0] fill);
        logic [LB*8-1:0] d;
        for (int k = 0; k < LB; k++) d[k*8 +: 8] = fill + 8'(k);
        return d;
    endfunction

    task automatic check(bit ok, string tag, string what,
                         logic [LB*8-1:0] act, logic [LB*8-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < NE; e++) begin
            m_valid[e] = 1'b0;
            m_line[e]  = '0;
            m_mask[e]  = '0;
            for (int b = 0; b < LB; b++) m_data[e][b] = 8'h00;
        end
    endtask

    // One cycle: drive, compare outputs with the model, clock, update model.
    task automatic cycle(bit v, logic [AW-1:0] line, logic [LB-1:0] be,
                         logic [7:0] fill, bit g, string tag);
        int sel, hit, fre;
        bit exp_ready;
        logic [LB*8-1:0] d, exp_d;
        @(negedge clk);
        d = mk_data(fill);
        st_valid = v; st_line = line; st_be = be; st_data = d; bus_grant = g;
        #1;
        sel = -1; hit = -1; fre = -1;
        for (int e = NE - 1; e >= 0; e--) begin
            if (m_valid[e]) sel = e;
            else fre = e;
        end
        for (int e = 0; e < NE; e++)
            if (m_valid[e] && m_line[e] == line && !(g && sel == e)) hit = e;
        exp_ready = (hit >= 0) || (fre >= 0);
        check(st_ready === exp_ready, tag, "st_ready (R5)",
              {255'b0, st_ready}, {255'b0, exp_ready});
        check(bus_req_valid === (sel >= 0), tag, "req valid (R7)",
              {255'b0, bus_req_valid}, {255'b0, (sel >= 0)});
        if (sel >= 0) begin
            for (int b = 0; b < LB; b++) exp_d[b*8 +: 8] = m_data[sel][b];
            check(bus_req_line === m_line[sel], tag, "req line (R7)",
                  {229'b0, bus_req_line}, {229'b0, m_line[sel]});
            check(bus_req_mask === m_mask[sel], tag, "req mask (R3)",
                  {224'b0, bus_req_mask}, {224'b0, m_mask[sel]});
            check(bus_req_kind === (&m_mask[sel]), tag, "req kind (R4)",
                  {255'b0, bus_req_kind}, {255'b0, (&m_mask[sel])});
            check(bus_req_data === exp_d, tag, "req data (R3)",
                  bus_req_data, exp_d);
        end
        @(posedge clk);
        if (g && sel >= 0) begin
            m_valid[sel] = 1'b0;
            m_mask[sel]  = '0;
        end
        if (v && exp_ready) begin
            if (hit >= 0) begin
                m_mask[hit] = m_mask[hit] | be;
                for (int b = 0; b < LB; b++)
                    if (be[b]) m_data[hit][b] = d[b*8 +: 8];
            end else begin
                m_valid[fre] = 1'b1;
                m_line[fre]  = line;
                m_mask[fre]  = be;
                for (int b = 0; b < LB; b++)
                    m_data[fre][b] = be[b] ? d[b*8 +: 8] : 8'h00;
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(bus_req_valid === 1'b0, "R1", "req valid after reset",
              {255'b0, bus_req_valid}, 256'd0);
        check(st_ready === 1'b1, "R1", "ready after reset",
              {255'b0, st_ready}, 256'd1);

        // R7 grant with nothing pending
        cycle(1'b0, '0, '0, 8'h0, 1'b1, "R7");
        cycle(1'b0, '0, '0, 8'h0, 1'b0, "R7");

        // table walk: merging and request kind
        foreach (VEC[i]) begin
            if (VEC[i][44])
                cycle(1'b0, '0, '0, 8'h0, 1'b1, "R4");
            else
                cycle(1'b1, 27'h100 + 27'(VEC[i][43:40]), VEC[i][39:8],
                      VEC[i][7:0], 1'b0, "R3");
        end
        cycle(1'b0, '0, '0, 8'h0, 1'b0, "R7");

        // R2 / R5: fill every entry, then a foreign line must stall
        for (int i = 0; i < NE; i++)
            cycle(1'b1, 27'h200 + 27'(i), 32'h1 << i, 8'(i * 16), 1'b0, "R2");
        cycle(1'b1, 27'h2FF, 32'hFFFF_FFFF, 8'hEE, 1'b0, "R5");
        cycle(1'b1, 27'h203, 32'h8000_0000, 8'hAA, 1'b0, "R5");
        // drain in index order; the stalled line must never show up
        for (int i = 0; i < NE; i++)
            cycle(1'b0, '0, '0, 8'h0, 1'b1, "R7");
        cycle(1'b0, '0, '0, 8'h0, 1'b0, "R5");

        // R6: store to the line being granted opens a fresh entry
        cycle(1'b1, 27'h300, 32'h0000_00FF, 8'h11, 1'b0, "R6");
        cycle(1'b1, 27'h300, 32'hFF00_0000, 8'h22, 1'b1, "R6");
        cycle(1'b1, 27'h300, 32'h00FF_FF00, 8'h33, 1'b0, "R6");
        cycle(1'b0, '0, '0, 8'h0, 1'b1, "R6");
        cycle(1'b0, '0, '0, 8'h0, 1'b0, "R6");

        // R4: mask completed at the last moment before the grant
        cycle(1'b1, 27'h400, 32'h7FFF_FFFF, 8'h44, 1'b0, "R4");
        cycle(1'b1, 27'h400, 32'h8000_0000, 8'h55, 1'b0, "R4");
        cycle(1'b0, '0, '0, 8'h0, 1'b1, "R4");
        cycle(1'b0, '0, '0, 8'h0, 1'b0, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule